// File: doc/BRIEF.md
# DMA Lost-Trigger Error Tracker

This block follows the trigger requests that arrive on each of a DMA controller's channels and records any that are lost. Each channel has three trigger sources: a hardware event line, a manual software set and a chain completion. Each source has its own pending latch in every channel. A trigger that arrives while its own latch is still pending is a lost event, and it sets the channel's bit in a sticky error vector. A service whose parameter entry turns out to be NULL sets the same bit. The service logic reports on the `svc_*` inputs which channel and which source it has serviced, and that report drops the matching pending latch.

Software reads the error vector as two 32-bit words and clears bits by writing ones to a pair of clear addresses. A single interrupt line reports errors. It pulses for one cycle when a new error appears while no error of any kind is present, including errors that other error groups report on `other_err_i`. Writing the evaluate address pulses the line again if any error is still present.

Top module: `evt_miss_tracker`

## Requirements
- R1: A trigger on a source whose latch for that channel is already pending sets the channel's error bit. The bit is readable from the cycle after that trigger.
- R2: The hardware, software and chain sources (service source codes 0, 1, 2) have separate latches. A pending trigger on one source never makes a trigger on another source a lost event.
- R3: If a trigger and a service report for the same channel and source arrive in the same cycle, no error is recorded and the latch stays pending.
- R4: A service report for a channel and source clears that latch, so the next trigger there is not a lost event.
- R5: A service report with `svc_null_i` high sets the error bit of `svc_ch_i`, whatever the latch state.
- R6: A read at address 0 returns channels 0–31 and a read at address 1 returns channels 32–63, with bit i of word w being channel 32·w+i. Any other address reads 0.
- R7: A write to address 2 clears the low-word bits where the data is 1, and a write to address 3 does the same for the high word. Zero bits, and writes to addresses 0 and 1, change nothing.
- R8: A bit that is set and cleared in the same cycle stays set.
- R9: `err_irq_o` pulses for one cycle, in the cycle after a bit is set, only if no error bit was set and `other_err_i` was low in the setting cycle.
- R10: A write to address 4 pulses `err_irq_o` in the next cycle if any error bit is set or `other_err_i` is high, and does nothing otherwise.
- R11: During and right after reset, all latches and error bits are zero and `err_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt_i | input | 64 | Hardware trigger pulses, one per channel |
| sw_evt_i | input | 64 | Manual software trigger pulses, one per channel |
| chain_evt_i | input | 64 | Chain-completion trigger pulses, one per channel |
| svc_valid_i | input | 1 | Service report valid |
| svc_ch_i | input | 6 | Serviced channel |
| svc_src_i | input | 2 | Serviced source: 0 hardware, 1 software, 2 chain |
| svc_null_i | input | 1 | Service found a NULL entry |
| other_err_i | input | 1 | Errors from other error groups are present |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| err_irq_o | output | 1 | Error interrupt pulse |

## Verification
Several functions can coincide in one cycle. A trigger can meet the service report for the same latch, and a new error can land on the bit that a clear write targets in that same cycle. The bench drives both pairings directly. Random traffic confined to sixteen channels also produces them often. A bench model applies R3 and R8 and judges every cycle by reading back both words and the interrupt line.

// File: rtl/evt_miss_pkg.sv
package evt_miss_pkg;
    localparam int NUM_SRC = 3;
    typedef enum logic [1:0] {
        SRC_HW    = 2'd0,
        SRC_SW    = 2'd1,
        SRC_CHAIN = 2'd2
    } trig_src_e;
endpackage

// File: rtl/evt_miss_chan.sv
module evt_miss_chan
    import evt_miss_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic [NUM_SRC-1:0] done_i,
    output logic               lost_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a trigger always (re)arms its latch; a service report drops it
        st_d.pend = trig_i | (st_q.pend & ~done_i);
        lost_o    = |(trig_i & st_q.pend & ~done_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evt_miss_errvec.sv
module evt_miss_errvec #(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    input  logic              eval_i,
    input  logic              other_err_i,
    output logic [NUM_CH-1:0] lost_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] lost;
        logic              irq;
    } err_st_t;

    err_st_t st_d, st_q;
    logic    quiet;

    always_comb begin
        st_d      = st_q;
        quiet     = (st_q.lost == '0) && !other_err_i;
        st_d.lost = (st_q.lost & ~clr_i) | set_i;
        st_d.irq  = ((|set_i) && quiet) || (eval_i && !quiet);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost_o = st_q.lost;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/evt_miss_regif.sv
module evt_miss_regif #(
    parameter int NUM_CH = 64,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [NUM_CH-1:0] lost_i,
    output logic [NUM_CH-1:0] clr_o,
    output logic              eval_o,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int NUM_WORDS = NUM_CH / WORD_W;
    localparam int EVAL_ADDR = 2 * NUM_WORDS;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign clr_o[w*WORD_W +: WORD_W] =
            (wr_i && addr_i == ADDR_W'(NUM_WORDS + w)) ? wdata_i : '0;
    end

    assign eval_o = wr_i && (addr_i == ADDR_W'(EVAL_ADDR));

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr_i == ADDR_W'(w)) rdata_o = lost_i[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/evt_miss_tracker.sv
module evt_miss_tracker
    import evt_miss_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int WORD_W = 32,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int NUM_WORDS = NUM_CH / WORD_W,
    localparam int ADDR_W    = $clog2(2 * NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hw_evt_i,
    input  logic [NUM_CH-1:0] sw_evt_i,
    input  logic [NUM_CH-1:0] chain_evt_i,
    input  logic              svc_valid_i,
    input  logic [CH_W-1:0]   svc_ch_i,
    input  logic [1:0]        svc_src_i,
    input  logic              svc_null_i,
    input  logic              other_err_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    output logic              err_irq_o
);
    logic [NUM_CH-1:0] lost_vec;
    logic [NUM_CH-1:0] set_vec;
    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] err_vec;
    logic              eval_wr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_SRC-1:0] trig;
        logic [NUM_SRC-1:0] done;
        logic               hit;

        assign hit  = svc_valid_i && (svc_ch_i == CH_W'(c));
        assign trig = {chain_evt_i[c], sw_evt_i[c], hw_evt_i[c]};
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign done[s] = hit && (svc_src_i == 2'(s));
        end

        evt_miss_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig_i (trig),
            .done_i (done),
            .lost_o (lost_vec[c])
        );

        assign set_vec[c] = lost_vec[c] | (hit && svc_null_i);
    end

    evt_miss_regif #(
        .NUM_CH (NUM_CH),
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .lost_i  (err_vec),
        .clr_o   (clr_vec),
        .eval_o  (eval_wr),
        .rdata_o (reg_rdata_o)
    );

    evt_miss_errvec #(
        .NUM_CH (NUM_CH)
    ) u_errvec (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_vec),
        .clr_i       (clr_vec),
        .eval_i      (eval_wr),
        .other_err_i (other_err_i),
        .lost_o      (err_vec),
        .irq_o       (err_irq_o)
    );
endmodule

// File: rtl/evt_miss_tracker_chk.sv
module evt_miss_tracker_chk #(
    parameter int NUM_CH = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] set_vec,
    input logic [NUM_CH-1:0] clr_vec,
    input logic [NUM_CH-1:0] err_vec,
    input logic              eval_wr,
    input logic              other_err,
    input logic              err_irq
);
    logic [NUM_CH-1:0] keep;
    assign keep = err_vec & ~clr_vec;

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_vec & $past(keep)) == $past(keep)));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((err_vec & $past(set_vec)) == $past(set_vec)));

    assert_first_err_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_vec) && (err_vec == '0) && !other_err) |=> err_irq);

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past((|set_vec) || eval_wr));

    assert_eval_reissue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_wr && ((err_vec != '0) || other_err)) |=> err_irq);
endmodule

bind evt_miss_tracker evt_miss_tracker_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .err_vec   (err_vec),
    .eval_wr   (eval_wr),
    .other_err (other_err_i),
    .err_irq   (err_irq_o)
);

// File: tb/evt_miss_tracker_tb.sv
module evt_miss_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] hw, sw, chn;
    logic        svc_valid, svc_null, other_err, reg_wr;
    logic [5:0]  svc_ch;
    logic [1:0]  svc_src;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        err_irq;

    int checks = 0, failures = 0;
    logic [63:0] m_pend [3];
    logic [63:0] m_err;
    bit done = 0;

    always #4 clk = ~clk;

    evt_miss_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .hw_evt_i(hw), .sw_evt_i(sw), .chain_evt_i(chn),
        .svc_valid_i(svc_valid), .svc_ch_i(svc_ch), .svc_src_i(svc_src),
        .svc_null_i(svc_null), .other_err_i(other_err), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .err_irq_o(err_irq));

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        hw = '0; sw = '0; chn = '0; svc_valid = 0; svc_null = 0; svc_ch = '0;
        svc_src = '0; other_err = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    function automatic logic [63:0] src_vec(int s);
        return (s == 0) ? hw : (s == 1) ? sw : chn;
    endfunction

    // advance one cycle; model computed from requirements, irq checked after the edge
    task automatic step(string tag);
        logic [63:0] set = '0, clr = '0, np [3];
        logic eval, quiet, irq_exp;
        for (int s = 0; s < 3; s++) begin
            logic [63:0] ack = (svc_valid && svc_src == 2'(s)) ? (64'd1 << svc_ch) : '0;
            set   |= src_vec(s) & m_pend[s] & ~ack;
            np[s]  = src_vec(s) | (m_pend[s] & ~ack);
        end
        if (svc_valid && svc_null) set |= 64'd1 << svc_ch;
        if (reg_wr && reg_addr == 3'd2) clr[31:0]  = reg_wdata;
        if (reg_wr && reg_addr == 3'd3) clr[63:32] = reg_wdata;
        eval    = reg_wr && reg_addr == 3'd4;
        quiet   = (m_err == '0) && !other_err;
        irq_exp = ((|set) && quiet) || (eval && !quiet);
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < 3; s++) m_pend[s] = np[s];
        m_err = (m_err & ~clr) | set;
        check({tag, " irq R9 R10"}, 64'(err_irq), 64'(irq_exp));
        idle();
    endtask

    task automatic check_words(string tag);
        reg_addr = 3'd0; #1; check({tag, " low R6"},  64'(reg_rdata), 64'(m_err[31:0]));
        reg_addr = 3'd1; #1; check({tag, " high R6"}, 64'(reg_rdata), 64'(m_err[63:32]));
        reg_addr = 3'd0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        for (int s = 0; s < 3; s++) m_pend[s] = '0;
        m_err = '0;
        repeat (3) @(negedge clk);
        check("R11 irq in reset", 64'(err_irq), 64'd0);
        rst_n = 1;
        check_words("R11 after reset");
        reg_addr = 3'd5; #1; check("R6 unmapped read", 64'(reg_rdata), 64'd0);

        // R1: repeated hardware trigger on channel 5
        hw[5] = 1; step("R1 first");
        hw[5] = 1; step("R1 second");
        check_words("R1 lost");

        // R2: software and chain on channel 40 while hardware idle
        sw[40] = 1; step("R2 a");
        hw[40] = 1; chn[40] = 1; step("R2 b");
        check_words("R2 separate");

        // R3: trigger and service together
        hw[7] = 1; step("R3 a");
        hw[7] = 1; svc_valid = 1; svc_ch = 6'd7; svc_src = 2'd0; step("R3 b");
        check_words("R3 no lost");
        hw[7] = 1; step("R3 still pending");
        check_words("R3 pending kept");

        // R4: service clears
        sw[3] = 1; step("R4 a");
        svc_valid = 1; svc_ch = 6'd3; svc_src = 2'd1; step("R4 b");
        sw[3] = 1; step("R4 c");
        check_words("R4 cleared");

        // R7: clears, zero bits and read-only writes
        reg_wr = 1; reg_addr = 3'd0; reg_wdata = '1; step("R7 ro");
        check_words("R7 ro write ignored");
        reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h0000_0020; step("R7 clr low");
        check_words("R7 clr low");
        reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h0; step("R7 zero");
        check_words("R7 zero write");

        // R5: NULL service on channel 63, and R9 first-error pulse
        reg_wr = 1; reg_addr = 3'd2; reg_wdata = '1; step("R5 pre");
        reg_wr = 1; reg_addr = 3'd3; reg_wdata = '1; step("R5 pre2");
        svc_valid = 1; svc_null = 1; svc_ch = 6'd63; svc_src = 2'd3; step("R5 null");
        check_words("R5 null bit");

        // R8: set and clear on same bit
        hw[63] = 1; step("R8 arm");
        hw[63] = 1; reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h8000_0000; step("R8 both");
        check_words("R8 set wins");

        // R10: evaluate with errors and with none
        reg_wr = 1; reg_addr = 3'd4; step("R10 reissue");
        reg_wr = 1; reg_addr = 3'd3; reg_wdata = '1; step("R10 clr");
        reg_wr = 1; reg_addr = 3'd4; step("R10 nothing");
        other_err = 1; reg_wr = 1; reg_addr = 3'd4; step("R10 other");

        // R9: no pulse when other errors present
        hw[63] = 1; other_err = 1; step("R9 blocked");
        check_words("R9 blocked");

        // random traffic on a few channels
        for (int i = 0; i < 4000; i++) begin
            for (int k = 0; k < 2; k++) begin
                int c = ($urandom % 2) ? int'($urandom % 8) : 40 + int'($urandom % 8);
                case ($urandom % 4)
                    0: hw[c]  = 1;
                    1: sw[c]  = 1;
                    2: chn[c] = 1;
                    default: ;
                endcase
            end
            if ($urandom % 2) begin
                svc_valid = 1;
                svc_ch  = ($urandom % 2) ? 6'($urandom % 8) : 6'(40 + $urandom % 8);
                svc_src = 2'($urandom % 3);
                svc_null = ($urandom % 10) == 0;
            end
            if (($urandom % 5) == 0) begin
                reg_wr = 1; reg_addr = 3'($urandom % 6); reg_wdata = $urandom;
            end
            other_err = ($urandom % 10) == 0;
            step("R1 R2 R3 R4 R5 R8 random");
            check_words("R7 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule